// File: doc/BRIEF.md
# Saturating Clear-on-Read Cell Counter

This block tallies the user cells that leave a cell-based transmit path. Two single-cycle strobes report a cell leaving the transmit FIFO and a cell leaving the cell insertion buffer. Both strobes can fire in the same cycle, and each one counts. A third strobe marks a generated idle cell. That strobe is accepted but is never counted. The running total never wraps. Once it reaches all-ones it stays there.

A host reads the total through a byte-wide read port. The port covers a window of consecutive addresses that starts at `BASE_ADDR`. The most significant byte sits at the lowest address. A read of that first byte does two things in one cycle: it latches the whole count into a snapshot register and it restarts the live counter. Reads of the remaining bytes then return bytes of that snapshot. The host therefore sees one coherent value even though cells keep arriving during the read sequence.

Top module: `cell_tally`

## Requirements
- R1: After reset, every byte of the window reads as 0x00.
- R2: Each cycle with `fifoStb` high and `insStb` low adds one to the count.
- R3: `insStb` alone adds one to the count. `fifoStb` and `insStb` high in the same cycle add two.
- R4: `idleStb` has no effect on the count.
- R5: The count stops at all-ones (0xFFFFFFFF at the default width) and does not wrap. Adding one or two to all-ones leaves all-ones.
- R6: The window holds the count most significant byte first. `BASE_ADDR+0` holds bits 31:24, `+1` holds bits 23:16, `+2` holds bits 15:8 and `+3` holds bits 7:0. Read data appears on `rdData` in the cycle after `rdEn`.
- R7: A read of `BASE_ADDR+0` returns the live top byte, copies the full count into the snapshot and clears the live count. Later reads of offsets 1 to 3 return bytes of that snapshot, even while counting goes on.
- R8: A cell strobe in the same cycle as the clearing read is counted into the restarted count, so no cell is lost.
- R9: A read outside the window returns 0x00 and clears nothing. `rdData` is 0x00 in any cycle that does not follow a read.
- R10: Reads of offsets 1 to 3 do not clear the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoStb | input | 1 | A cell left the transmit FIFO |
| insStb | input | 1 | A cell left the insertion buffer |
| idleStb | input | 1 | An idle cell was generated (not counted) |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W (16) | Read address |
| rdData | output | 8 | Registered read data |

## Verification
The bench builds two copies of the block. The first uses the default 32-bit count and base 0x0040. It exercises byte order, snapshot coherency and coincident events, and it uses a burst of 70000 cells so that byte 2 holds a nonzero value. The second uses a 16-bit count at base 0x0100. With that width about 33000 cycles of traffic reach the all-ones clamp, so saturation and the clear that follows can be checked directly.

// File: rtl/cell_tally_pkg.sv
package cell_tally_pkg;
  // Strobes passed from read decode to the counting datapath
  typedef struct packed {
    logic       hit;      // read falls inside the window
    logic       snapTake; // read of the first (most significant) byte
    logic [7:0] byteIdx;  // offset inside the window
  } tally_ctrl_t;
endpackage

// File: rtl/cell_tally_ctrl.sv
module cell_tally_ctrl
  import cell_tally_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_BYTES = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output tally_ctrl_t       ctrl
);
  logic [ADDR_W-1:0] offset;
  logic              inWin;

  always_comb begin
    offset = rdAddr - BASE_ADDR;
    inWin  = (rdAddr >= BASE_ADDR) && (offset < ADDR_W'(NUM_BYTES));
    ctrl.hit      = rdEn && inWin;
    ctrl.snapTake = rdEn && inWin && (offset == '0);
    ctrl.byteIdx  = 8'(offset);
  end
endmodule

// File: rtl/cell_tally_dp.sv
module cell_tally_dp
  import cell_tally_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int NUM_BYTES = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoStb,
  input  logic             insStb,
  input  tally_ctrl_t      ctrl,
  output logic [CNT_W-1:0] liveCnt,
  output logic [7:0]       rdData
);
  logic [CNT_W-1:0] snapReg;
  logic [1:0]       incAmt;
  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W:0]   sumExt;
  logic [CNT_W-1:0] nextCnt;
  logic [7:0]       liveBytes [NUM_BYTES];
  logic [7:0]       snapBytes [NUM_BYTES];
  logic [7:0]       selByte;

  // Byte views in address order: index 0 is the most significant byte
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_bytes
    assign liveBytes[g] = liveCnt[(NUM_BYTES-1-g)*8 +: 8];
    assign snapBytes[g] = snapReg[(NUM_BYTES-1-g)*8 +: 8];
  end

  always_comb begin
    incAmt  = {1'b0, fifoStb} + {1'b0, insStb};
    baseCnt = ctrl.snapTake ? '0 : liveCnt;
    sumExt  = {1'b0, baseCnt} + {{(CNT_W-1){1'b0}}, incAmt};
    nextCnt = sumExt[CNT_W] ? '1 : sumExt[CNT_W-1:0];
  end

  always_comb begin
    selByte = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (ctrl.byteIdx == 8'(i)) selByte = snapBytes[i];
    end
    if (ctrl.snapTake) selByte = liveBytes[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCnt <= '0;
      snapReg <= '0;
      rdData  <= '0;
    end else begin
      liveCnt <= nextCnt;
      if (ctrl.snapTake) snapReg <= liveCnt;
      rdData  <= ctrl.hit ? selByte : '0;
    end
  end
endmodule

// File: rtl/cell_tally.sv
module cell_tally
  import cell_tally_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  localparam int NUM_BYTES = CNT_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoStb,
  input  logic              insStb,
  input  logic              idleStb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  tally_ctrl_t      ctrl;
  logic [CNT_W-1:0] liveCnt;

  cell_tally_ctrl #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BASE_ADDR(BASE_ADDR)
  ) ctrlI (
    .rdEn(rdEn), .rdAddr(rdAddr), .ctrl(ctrl)
  );

  cell_tally_dp #(.CNT_W(CNT_W)) dpI (
    .clk(clk), .rstN(rstN), .fifoStb(fifoStb), .insStb(insStb),
    .ctrl(ctrl), .liveCnt(liveCnt), .rdData(rdData)
  );
endmodule

// File: rtl/cell_tally_chk.sv
module cell_tally_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoStb,
  input logic              insStb,
  input logic              idleStb,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic [CNT_W-1:0]  liveCnt
);
  logic clrRd;
  assign clrRd = rdEn && (rdAddr == BASE_ADDR);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt == '1 && !clrRd) |=> (liveCnt == '1));

  assert_idle_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoStb && !insStb && !clrRd) |=> $stable(liveCnt));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoStb && !insStb && !clrRd && liveCnt != '1)
      |=> (liveCnt == $past(liveCnt) + CNT_W'(1)));

  assert_clear_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    clrRd |=> (liveCnt <= CNT_W'(2)));

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == 8'h00));
endmodule

bind cell_tally cell_tally_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) chkI (
  .clk(clk), .rstN(rstN), .fifoStb(fifoStb), .insStb(insStb),
  .idleStb(idleStb), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .liveCnt(liveCnt)
);

// File: tb/cell_tally_tb_top.sv
module cell_tally_tb_top;
  localparam logic [15:0] BASE  = 16'h0040;
  localparam logic [15:0] SBASE = 16'h0100;
  // {nFifo, nIns, nBoth, nIdle}
  localparam logic [31:0] VEC [6] = '{
    {8'd3,  8'd0,  8'd0,  8'd0},
    {8'd0,  8'd5,  8'd0,  8'd7},
    {8'd2,  8'd2,  8'd4,  8'd0},
    {8'd0,  8'd0,  8'd0,  8'd9},
    {8'd200,8'd100,8'd50, 8'd30},
    {8'd1,  8'd0,  8'd255,8'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoStb = 0, insStb = 0, idleStb = 0, rdEn = 0;
  logic [15:0] rdAddr = '0;
  logic [7:0]  rdData;
  logic sFifo = 0, sIns = 0, sRdEn = 0;
  logic [15:0] sRdAddr = '0;
  logic [7:0]  sRdData;
  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cell_tally dut_i (
    .clk(clk), .rstN(rstN), .fifoStb(fifoStb), .insStb(insStb),
    .idleStb(idleStb), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  cell_tally #(.CNT_W(16), .BASE_ADDR(SBASE)) satDut_i (
    .clk(clk), .rstN(rstN), .fifoStb(sFifo), .insStb(sIns),
    .idleStb(1'b0), .rdEn(sRdEn), .rdAddr(sRdAddr), .rdData(sRdData)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic burst(input bit f, input bit i, input bit idl, input int n);
    @(negedge clk);
    fifoStb = f; insStb = i; idleStb = idl;
    repeat (n) @(negedge clk);
    fifoStb = 0; insStb = 0; idleStb = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1; rdAddr = a;
    @(negedge clk);
    rdEn = 0;
    d = rdData;
  endtask

  task automatic rdAll(output logic [31:0] v);
    logic [7:0] b3, b2, b1, b0;
    rd(BASE, b3); rd(BASE + 16'd1, b2); rd(BASE + 16'd2, b1); rd(BASE + 16'd3, b0);
    v = {b3, b2, b1, b0};
  endtask

  task automatic srd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    sRdEn = 1; sRdAddr = a;
    @(negedge clk);
    sRdEn = 0;
    d = sRdData;
  endtask

  initial begin
    logic [31:0] v;
    logic [7:0]  b, b2, b1, b0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    rd(BASE + 16'd3, b); chk(b, 0, "R1 byte0 after reset");
    rdAll(v); chk(v, 0, "R1 full count after reset");

    // Vector table: R2 R3 R4
    for (int k = 0; k < 6; k++) begin
      int nf, ni, nb, nd;
      nf = VEC[k][31:24]; ni = VEC[k][23:16]; nb = VEC[k][15:8]; nd = VEC[k][7:0];
      burst(1, 0, 0, nf);
      burst(0, 1, 0, ni);
      burst(1, 1, 0, nb);
      burst(0, 0, 1, nd);
      rdAll(v);
      chk(v, 32'(nf + ni + 2 * nb), $sformatf("R2 R3 R4 vector %0d", k));
    end

    // R4: idle overlapping a FIFO burst adds nothing extra
    burst(1, 0, 1, 6);
    rdAll(v); chk(v, 6, "R4 idle with fifo");

    // R6: byte order, 70000 = 0x00011170
    burst(1, 1, 0, 35000);
    rdAll(v);
    chk(v[23:16], 8'h01, "R6 byte2");
    chk(v[15:8], 8'h11, "R6 byte1");
    chk(v[7:0], 8'h70, "R6 byte0");

    // R7: snapshot stays while counting continues
    burst(1, 0, 0, 5);
    rd(BASE, b);
    burst(1, 0, 0, 3);
    rd(BASE + 16'd3, b0); chk(b0, 5, "R7 snapshot byte0");
    rdAll(v); chk(v, 3, "R7 live restarted");

    // R8: events coincident with clearing read
    burst(0, 1, 0, 4);
    @(negedge clk);
    rdEn = 1; rdAddr = BASE; fifoStb = 1; insStb = 1;
    @(negedge clk);
    rdEn = 0; fifoStb = 0; insStb = 0;
    rd(BASE + 16'd3, b0); chk(b0, 4, "R8 snapshot before clear");
    rdAll(v); chk(v, 2, "R8 coincident cells kept");

    // R9: out-of-window reads
    burst(1, 0, 0, 7);
    rd(BASE + 16'd4, b); chk(b, 0, "R9 above window");
    rd(BASE - 16'd1, b); chk(b, 0, "R9 below window");
    rdAll(v); chk(v, 7, "R9 nothing cleared");

    // R10: lower byte reads do not clear
    burst(0, 1, 0, 9);
    rd(BASE + 16'd3, b); rd(BASE + 16'd2, b); rd(BASE + 16'd1, b);
    rdAll(v); chk(v, 9, "R10 no clear on lower bytes");

    // R5: saturation on 16-bit copy
    @(negedge clk);
    sFifo = 1; sIns = 1;
    repeat (32767) @(negedge clk);
    sIns = 0;
    @(negedge clk);
    sIns = 1;
    repeat (3) @(negedge clk);
    sFifo = 0; sIns = 0;
    srd(SBASE, b1); srd(SBASE + 16'd1, b0);
    chk({b1, b0}, 16'hFFFF, "R5 clamp at all-ones");
    srd(SBASE, b1); srd(SBASE + 16'd1, b0);
    chk({b1, b0}, 0, "R5 cleared after read");
    b2 = 0;

    done = 1;
    summary();
    $finish;
  end
endmodule